// File: doc/BRIEF.md
# Configurable External Interrupt Detector

This block watches a set of external input pins and raises interrupts when a pin shows the condition its configuration asks for. Each pin has its own detection mode: a rising edge, a falling edge, either edge, a high level, a low level, or nothing at all. Each pin can also have a three-sample majority filter that rejects single-cycle glitches. Every pin is brought into the single block clock through two flip-flops before it is examined.

A detected condition sets a sticky per-pin flag. Software clears a flag by writing a 1 to its bit. The two mode classes re-arm differently after a clear. An edge mode needs a new edge before the flag sets again. A level mode sets the flag again at once while the pin still matches. A per-pin enable mask selects which flags drive the single interrupt request. Separately, a per-pin event line pulses for one cycle each time the pin's condition starts to hold.

Configuration is written one pin at a time through a small write port. Flag clears and mask updates are each written as a whole vector.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset, all flags, event pulses and the interrupt request are 0, and every pin's mode is none.
- R2: The 3-bit mode code is interpreted as follows: 0 none, 1 rising edge, 2 falling edge, 3 both edges, 4 high level, 5 low level, and 6 or 7 also none. With rising mode, a 0-to-1 change on the pin sets the flag.
- R3: With falling mode, a 1-to-0 change sets the flag. With both-edges mode, either change sets it.
- R4: A flag stays set until a clear write has a 1 in that bit. Clear-write bits that are 0 leave their flags unchanged.
- R5: In an edge mode, a cleared flag stays clear while the pin holds steady.
- R6: In a level mode, clearing a flag while the pin still matches leaves the flag reading 1 on the next cycle. Once the pin stops matching, a clear leaves the flag at 0.
- R7: If a clear write and a new detection fall in the same cycle, the flag ends up set.
- R8: With the filter on, the conditioned pin value is 1 only when at least two of its last three samples are 1. A lone one-cycle pulse is ignored. A 1,0,1 sample pattern counts as a 1.
- R9: Without the filter, the event pulse appears 2 cycles after a pin change and the flag 3 cycles after it. With the filter, these are 4 and 5 cycles. Edge-mode detection therefore stays within the bound of 4 cycles unfiltered and 6 cycles filtered.
- R10: The interrupt request is the OR, over all pins, of flag AND enable. The enable register is loaded by a mask write and takes effect on the next cycle.
- R11: A pin's event output is high for exactly one cycle each time its condition changes from not met to met. It does not depend on the flag state.
- R12: A pin whose mode is none (code 0, 6 or 7) never produces an event and never sets its flag.
- R13: Writing a pin's configuration drops its edge history for one cycle. A new edge mode therefore detects no edge against a pin level that has not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| pin_i | input | NPINS | Raw external pins |
| cfg_we_i | input | 1 | Write one pin's configuration |
| cfg_idx_i | input | IW | Pin index for the configuration write |
| cfg_sense_i | input | 3 | Mode code (see R2) |
| cfg_filt_i | input | 1 | Majority filter enable |
| ien_we_i | input | 1 | Load the interrupt enable mask |
| ien_data_i | input | NPINS | New enable mask |
| clr_we_i | input | 1 | Write-one-to-clear strobe for the flags |
| clr_data_i | input | NPINS | Flag bits to clear |
| flag_o | output | NPINS | Sticky per-pin flags |
| event_o | output | NPINS | One-cycle per-pin detection pulses |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check four rules on every cycle:
- A flag holds unless its clear bit is written.
- Every event leaves its flag set on the next cycle, even against a simultaneous clear.
- An event never lasts two cycles.
- A pin in mode none never raises its flag.

The directed scenarios cover the behaviours that need a known stimulus:
- exact detection latencies with and without the filter;
- majority rejection of glitches;
- the different re-arming of edge and level modes;
- the effect of the enable mask;
- the absence of a false edge after reconfiguration.

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
  parameter int NPINS = 4,
  localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic             cfg_we_i,
  input  logic [IW-1:0]    cfg_idx_i,
  input  logic [2:0]       cfg_sense_i,
  input  logic             cfg_filt_i,
  input  logic             ien_we_i,
  input  logic [NPINS-1:0] ien_data_i,
  input  logic             clr_we_i,
  input  logic [NPINS-1:0] clr_data_i,
  output logic [NPINS-1:0] flag_o,
  output logic [NPINS-1:0] event_o,
  output logic             irq_o
);

  logic [NPINS-1:0] sync1, sync2, cur, prev, cond, cond_q, flag_q, ien_q;
  logic [NPINS-1:0] clr;

  assign clr = clr_we_i ? clr_data_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      prev   <= '0;
      cond_q <= '0;
      flag_q <= '0;
      ien_q  <= '0;
    end else begin
      sync1  <= pin_i;
      sync2  <= sync1;
      prev   <= cur;
      cond_q <= cond;
      flag_q <= (flag_q & ~clr) | cond;
      if (ien_we_i) ien_q <= ien_data_i;
    end
  end

  assign flag_o  = flag_q;
  assign event_o = cond & ~cond_q;
  assign irq_o   = |(flag_q & ien_q);

  for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
    logic [2:0] sense_q;
    logic       filt_q;
    logic [2:0] hist_q;
    logic       armed_q;
    logic       sel;
    logic       maj;

    assign sel = cfg_we_i && (cfg_idx_i == IW'(gi));
    assign maj = (hist_q[0] & hist_q[1]) | (hist_q[0] & hist_q[2]) | (hist_q[1] & hist_q[2]);
    assign cur[gi] = filt_q ? maj : sync2[gi];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sense_q <= 3'd0;
        filt_q  <= 1'b0;
        hist_q  <= 3'b000;
        armed_q <= 1'b0;
      end else begin
        hist_q  <= {hist_q[1:0], sync2[gi]};
        armed_q <= !sel;
        if (sel) begin
          sense_q <= cfg_sense_i;
          filt_q  <= cfg_filt_i;
        end
      end
    end

    always_comb begin
      case (sense_q)
        3'd1:    cond[gi] = armed_q & cur[gi] & ~prev[gi];
        3'd2:    cond[gi] = armed_q & ~cur[gi] & prev[gi];
        3'd3:    cond[gi] = armed_q & (cur[gi] ^ prev[gi]);
        3'd4:    cond[gi] = cur[gi];
        3'd5:    cond[gi] = ~cur[gi];
        default: cond[gi] = 1'b0;
      endcase
    end

    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[gi] && !clr[gi]) |=> flag_o[gi]);

    assert_event_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      event_o[gi] |=> flag_o[gi]);

    assert_event_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      event_o[gi] |=> !event_o[gi]);

    assert_none_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ((sense_q == 3'd0 || sense_q > 3'd5) && !flag_o[gi]) |=> !flag_o[gi]);
  end

endmodule

// File: tb/test_ext_irq_detect.sv
`timescale 1ns/1ps
module test_ext_irq_detect;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin = '0;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_idx = '0;
  logic [2:0]   cfg_sense = '0;
  logic         cfg_filt = 1'b0;
  logic         ien_we = 1'b0;
  logic [N-1:0] ien_data = '0;
  logic         clr_we = 1'b0;
  logic [N-1:0] clr_data = '0;
  logic [N-1:0] flag, evt;
  logic         irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ext_irq_detect #(.NPINS(N)) i_ext_irq_detect (
    .clk(clk), .rst_n(rst_n), .pin_i(pin),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_sense_i(cfg_sense), .cfg_filt_i(cfg_filt),
    .ien_we_i(ien_we), .ien_data_i(ien_data),
    .clr_we_i(clr_we), .clr_data_i(clr_data),
    .flag_o(flag), .event_o(evt), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pin = '0; cfg_we = 0; ien_we = 0; clr_we = 0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic cfg(input int idx, input int sense, input bit filt);
    cfg_we = 1; cfg_idx = 2'(idx); cfg_sense = 3'(sense); cfg_filt = filt;
    tick(1);
    cfg_we = 0;
  endtask

  task automatic clear(input logic [N-1:0] m);
    clr_we = 1; clr_data = m;
    tick(1);
    clr_we = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check(flag == 0, "R1 flags", flag, 0);
    check(evt == 0, "R1 events", evt, 0);
    check(irq == 0, "R1 irq", irq, 0);
  endtask

  task automatic t_rise();
    do_reset();
    cfg(0, 1, 0);
    pin[0] = 1;
    tick(2);
    check(evt[0] == 1, "R2 rising event", evt[0], 1);
    check(flag[0] == 0, "R9 flag not yet", flag[0], 0);
    tick(1);
    check(flag[0] == 1, "R9 flag after 3", flag[0], 1);
    check(evt[0] == 0, "R11 pulse ends", evt[0], 0);
  endtask

  task automatic t_fall_both();
    do_reset();
    pin[1] = 1;
    tick(4);
    cfg(1, 2, 0);
    tick(1);
    pin[1] = 0;
    tick(3);
    check(flag[1] == 1, "R3 falling", flag[1], 1);
    cfg(2, 3, 0);
    pin[2] = 1;
    tick(3);
    check(flag[2] == 1, "R3 both rise", flag[2], 1);
    clear(4'b0100);
    check(flag[2] == 0, "R3 cleared", flag[2], 0);
    pin[2] = 0;
    tick(3);
    check(flag[2] == 1, "R3 both fall", flag[2], 1);
  endtask

  task automatic t_sticky_edge();
    do_reset();
    cfg(0, 1, 0);
    pin[0] = 1;
    tick(3);
    tick(5);
    check(flag[0] == 1, "R4 sticky", flag[0], 1);
    clear(4'b1110);
    check(flag[0] == 1, "R4 zero bit ignored", flag[0], 1);
    clear(4'b0001);
    check(flag[0] == 0, "R4 cleared", flag[0], 0);
    tick(5);
    check(flag[0] == 0, "R5 edge needs new edge", flag[0], 0);
  endtask

  task automatic t_level();
    do_reset();
    cfg(3, 4, 0);
    pin[3] = 1;
    tick(3);
    check(flag[3] == 1, "R6 high level", flag[3], 1);
    clear(4'b1000);
    check(flag[3] == 1, "R6 level re-sets", flag[3], 1);
    pin[3] = 0;
    tick(3);
    clear(4'b1000);
    check(flag[3] == 0, "R6 clear after release", flag[3], 0);
    tick(3);
    check(flag[3] == 0, "R6 stays clear", flag[3], 0);
    cfg(3, 5, 0);
    tick(2);
    check(flag[3] == 1, "R6 low level", flag[3], 1);
  endtask

  task automatic t_setwins();
    do_reset();
    cfg(2, 3, 0);
    pin[2] = 1;
    tick(3);
    pin[2] = 0;
    tick(2);
    check(evt[2] == 1, "R11 event with flag set", evt[2], 1);
    clr_we = 1; clr_data = 4'b0100;
    tick(1);
    clr_we = 0;
    check(flag[2] == 1, "R7 set wins", flag[2], 1);
    clear(4'b0100);
    check(flag[2] == 0, "R7 later clear", flag[2], 0);
  endtask

  task automatic t_filter();
    do_reset();
    cfg(0, 1, 1);
    tick(5);
    pin[0] = 1; tick(1); pin[0] = 0;
    tick(8);
    check(flag[0] == 0, "R8 glitch rejected", flag[0], 0);
    pin[0] = 1; tick(1); pin[0] = 0; tick(1); pin[0] = 1; tick(1); pin[0] = 0;
    tick(8);
    check(flag[0] == 1, "R8 101 passes", flag[0], 1);
    clear(4'b0001);
    tick(3);
    pin[0] = 1;
    tick(3);
    check(evt[0] == 0, "R9 filtered early", evt[0], 0);
    tick(1);
    check(evt[0] == 1, "R9 filtered event at 4", evt[0], 1);
    check(flag[0] == 0, "R9 filtered flag not yet", flag[0], 0);
    tick(1);
    check(flag[0] == 1, "R9 filtered flag at 5", flag[0], 1);
  endtask

  task automatic t_irq();
    do_reset();
    cfg(1, 1, 0);
    pin[1] = 1;
    tick(3);
    check(irq == 0, "R10 masked", irq, 0);
    ien_we = 1; ien_data = 4'b1101; tick(1); ien_we = 0;
    check(irq == 0, "R10 other enables", irq, 0);
    ien_we = 1; ien_data = 4'b0010; tick(1); ien_we = 0;
    check(irq == 1, "R10 enabled", irq, 1);
    clear(4'b0010);
    check(irq == 0, "R10 after clear", irq, 0);
  endtask

  task automatic t_none();
    int seen;
    do_reset();
    cfg(0, 0, 0);
    cfg(1, 6, 0);
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      pin[1:0] = ~pin[1:0];
      tick(1);
      if (evt[1:0] != 0) seen++;
    end
    tick(3);
    check(seen == 0, "R12 no events", seen, 0);
    check(flag[1:0] == 0, "R12 no flags", flag[1:0], 0);
  endtask

  task automatic t_cfgchange();
    int seen;
    do_reset();
    pin[0] = 1;
    tick(5);
    cfg(0, 1, 0);
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      tick(1);
      if (evt[0]) seen++;
    end
    check(flag[0] == 0, "R13 no false edge", flag[0], 0);
    cfg(0, 3, 1);
    for (int i = 0; i < 4; i++) begin
      tick(1);
      if (evt[0]) seen++;
    end
    check(seen == 0, "R13 no false event", seen, 0);
    check(flag[0] == 0, "R13 filter switch", flag[0], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_rise();
    t_fall_both();
    t_sticky_edge();
    t_level();
    t_setwins();
    t_filter();
    t_irq();
    t_none();
    t_cfgchange();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule